// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This block brings a serial PHY out of reset and waits until its receive PLL is stable. Its only path to the PHY is a narrow control port. The block drives a 16-bit data bus and four strobes: address capture, data capture, write and read. The PHY answers with one acknowledge line and a 16-bit read-data bus. A one-cycle enable pulse starts the sequence. The block captures the address of the PHY clock/reset register, captures the reset value, and pulses the write strobe. It does not wait for an acknowledge after the write, because a PHY that is resetting cannot answer.

The block then polls the lane status register inside the PHY. Before each poll it waits a programmable idle gap. It captures the status address, performs a read handshake, and tests the PLL-stable bit. The block stops when it sees lock, or when the poll budget is used up, or when any handshake fails to complete within its acknowledge limit. It finishes with a one-cycle done pulse and a sticky result: ready or timeout. The next enable clears the result.

Top module: `phy_lock_sequencer`

## Requirements
- R1: While reset is held and after it is released, all four strobes, the done pulse, and the ready and timeout flags are low until an enable arrives.
- R2: After an enable the first operation is an address capture with the bus at 0x7F3F. Next comes a data capture with the bus at 0x0001. Then the write strobe is held for WR_HOLD cycles without waiting for any acknowledge. The write comes before any read.
- R3: Every capture or read handshake holds its strobe until the acknowledge is high, drops it, and then waits for the acknowledge to go low. At most one strobe is high at a time, and the data bus does not change while a strobe is high.
- R4: Before each poll the block keeps all strobes low for at least POLL_GAP cycles.
- R5: Each poll is an address capture with the bus at 0x2003 followed by a read. The PLL counts as locked only when bit 1 of the returned data is 1. All other bits have no effect.
- R6: On lock, ready is set, done pulses for exactly one cycle, and the block issues no further strobes.
- R7: If MAX_POLLS reads return bit 1 clear, the block sets timeout and pulses done after exactly MAX_POLLS reads.
- R8: If an acknowledge does not rise, or does not fall, within ACK_LIMIT cycles, the sequence aborts at once. All strobes drop, timeout is set, done pulses, and no further operation is issued.
- R9: An enable clears ready and timeout and restarts the sequence. An enable that arrives while a sequence is running has no effect.
- R10: Ready and timeout are never high together, and ready and timeout stay at their value until the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | One-cycle start pulse |
| phy_bus | output | 16 | Address or data presented to the PHY control port |
| phy_cap_addr | output | 1 | Address-capture strobe |
| phy_cap_data | output | 1 | Data-capture strobe |
| phy_wr | output | 1 | Write strobe (no acknowledge expected) |
| phy_rd | output | 1 | Read strobe |
| phy_ack | input | 1 | Handshake acknowledge from the PHY |
| phy_dout | input | 16 | Read data from the PHY |
| seq_done | output | 1 | One-cycle pulse when the sequence ends |
| seq_ready | output | 1 | Sticky: the receive PLL reported lock |
| seq_timeout | output | 1 | Sticky: poll budget used up or handshake stalled |

## Verification
The PHY model never acknowledges the write strobe. A design that waits for a write acknowledge therefore times out instead of polling.

Status words arrive with every bit except bit 1 set. A design that tests the wrong bit, or tests any nonzero value, reports lock too early.

The lock poll varies from the first poll to exactly the last allowed poll and beyond it. This catches an off-by-one error in the poll budget, which would show up as one read too many or one too few.

The model also holds the acknowledge low during a read, and holds it high after an address capture. A design that does not abort keeps strobing or hangs without a result. A second enable during a run shows whether a busy sequencer restarts, which would produce a second reset write.

// File: rtl/phy_lock_pkg.sv
package phy_lock_pkg;

    localparam int CR_W = 16;

    // PHY-internal register addresses and values used by the sequence
    localparam logic [CR_W-1:0] REG_CLK_RST   = 16'h7F3F;
    localparam logic [CR_W-1:0] VAL_RST_REQ   = 16'h0001;
    localparam logic [CR_W-1:0] REG_LANE_STAT = 16'h2003;
    localparam int              PLL_OK_BIT    = 1;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } cr_op_e;

    typedef struct packed {
        cr_op_e          op;
        logic [CR_W-1:0] data;
    } cr_req_t;

    typedef struct packed {
        logic cap_addr;
        logic cap_data;
        logic wr;
        logic rd;
    } cr_strobe_t;

    typedef enum logic [2:0] {
        M_IDLE,
        M_SETUP,
        M_HI,
        M_LO,
        M_WR
    } mst_state_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RST_ADDR,
        S_RST_WR,
        S_GAP_LOAD,
        S_GAP,
        S_POLL_ADDR,
        S_POLL_RD
    } seq_state_e;

    function automatic logic pll_is_locked(input logic [CR_W-1:0] word);
        return word[PLL_OK_BIT];
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cr_port_master.sv
module cr_port_master
    import phy_lock_pkg::*;
#(
    parameter int ACK_LIMIT = 1000,
    parameter int WR_HOLD   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  cr_req_t         req,
    output logic            op_done,
    output logic            op_err,
    output logic [CR_W-1:0] rdata,
    output cr_strobe_t      strb,
    output logic [CR_W-1:0] bus,
    input  logic            ack,
    input  logic [CR_W-1:0] dout
);
    localparam int CNT_MAX = max2(ACK_LIMIT, WR_HOLD);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] ACK_LAST = CNT_W'(ACK_LIMIT - 1);
    localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(WR_HOLD - 1);

    mst_state_e       st;
    cr_op_e           op_q;
    logic [CR_W-1:0]  bus_q;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= M_IDLE;
            op_q    <= OP_ADDR;
            bus_q   <= '0;
            cnt     <= '0;
            op_done <= 1'b0;
            op_err  <= 1'b0;
            rdata   <= '0;
        end else begin
            op_done <= 1'b0;
            op_err  <= 1'b0;
            unique case (st)
                M_IDLE: begin
                    if (go) begin
                        op_q <= req.op;
                        if (req.op != OP_READ)
                            bus_q <= req.data;
                        cnt <= '0;
                        st  <= M_SETUP;
                    end
                end
                M_SETUP: begin
                    cnt <= '0;
                    st  <= M_HI;
                end
                M_HI: begin
                    if (ack) begin
                        if (op_q == OP_READ)
                            rdata <= dout;
                        cnt <= '0;
                        st  <= M_LO;
                    end else if (cnt == ACK_LAST) begin
                        op_err <= 1'b1;
                        st     <= M_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                M_LO: begin
                    if (!ack) begin
                        cnt <= '0;
                        if (op_q == OP_WRITE) begin
                            st <= M_WR;
                        end else begin
                            op_done <= 1'b1;
                            st      <= M_IDLE;
                        end
                    end else if (cnt == ACK_LAST) begin
                        op_err <= 1'b1;
                        st     <= M_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                M_WR: begin
                    if (cnt == WR_LAST) begin
                        op_done <= 1'b1;
                        st      <= M_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= M_IDLE;
            endcase
        end
    end

    always_comb begin
        strb.cap_addr = (st == M_HI) && (op_q == OP_ADDR);
        strb.cap_data = (st == M_HI) && (op_q == OP_WRITE);
        strb.rd       = (st == M_HI) && (op_q == OP_READ);
        strb.wr       = (st == M_WR);
    end

    assign bus = bus_q;

    logic any_stb;
    assign any_stb = strb.cap_addr | strb.cap_data | strb.rd | strb.wr;

    p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strb.cap_addr, strb.cap_data, strb.wr, strb.rd}));

    p_bus_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (any_stb && $past(any_stb)) |-> $stable(bus));

    p_done_err_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(op_done && op_err));

    p_err_drops_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        op_err |-> !any_stb);

endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
    parameter int SPAN = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int GW = $clog2(SPAN + 1);
    localparam logic [GW-1:0] SPAN_V = GW'(SPAN);

    logic [GW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (load)
            left <= SPAN_V;
        else if (left != '0)
            left <= left - 1'b1;
    end

    assign expired = (left == '0);

    p_gap_hold_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> !expired);

endmodule

// File: rtl/phy_lock_seq.sv
module phy_lock_seq
    import phy_lock_pkg::*;
#(
    parameter int MAX_POLLS = 100
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    output logic            go,
    output cr_req_t         req,
    input  logic            op_done,
    input  logic            op_err,
    input  logic [CR_W-1:0] rdata,
    output logic            gap_load,
    input  logic            gap_expired,
    output logic            done_o,
    output logic            ready_o,
    output logic            timeout_o
);
    localparam int PC_W = $clog2(MAX_POLLS + 1);
    localparam logic [PC_W-1:0] LAST_POLL = PC_W'(MAX_POLLS - 1);

    seq_state_e      st;
    logic            pend;
    logic [PC_W-1:0] pcnt;

    assign gap_load = (st == S_GAP_LOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            pend      <= 1'b0;
            pcnt      <= '0;
            go        <= 1'b0;
            req       <= '{op: OP_ADDR, data: '0};
            done_o    <= 1'b0;
            ready_o   <= 1'b0;
            timeout_o <= 1'b0;
        end else begin
            go     <= 1'b0;
            done_o <= 1'b0;
            if (pend && op_err) begin
                pend      <= 1'b0;
                timeout_o <= 1'b1;
                done_o    <= 1'b1;
                st        <= S_IDLE;
            end else begin
                unique case (st)
                    S_IDLE: begin
                        if (enable) begin
                            ready_o   <= 1'b0;
                            timeout_o <= 1'b0;
                            pcnt      <= '0;
                            st        <= S_RST_ADDR;
                        end
                    end
                    S_RST_ADDR: begin
                        if (!pend) begin
                            go   <= 1'b1;
                            req  <= '{op: OP_ADDR, data: REG_CLK_RST};
                            pend <= 1'b1;
                        end else if (op_done) begin
                            pend <= 1'b0;
                            st   <= S_RST_WR;
                        end
                    end
                    S_RST_WR: begin
                        if (!pend) begin
                            go   <= 1'b1;
                            req  <= '{op: OP_WRITE, data: VAL_RST_REQ};
                            pend <= 1'b1;
                        end else if (op_done) begin
                            pend <= 1'b0;
                            st   <= S_GAP_LOAD;
                        end
                    end
                    S_GAP_LOAD: st <= S_GAP;
                    S_GAP: begin
                        if (gap_expired)
                            st <= S_POLL_ADDR;
                    end
                    S_POLL_ADDR: begin
                        if (!pend) begin
                            go   <= 1'b1;
                            req  <= '{op: OP_ADDR, data: REG_LANE_STAT};
                            pend <= 1'b1;
                        end else if (op_done) begin
                            pend <= 1'b0;
                            st   <= S_POLL_RD;
                        end
                    end
                    S_POLL_RD: begin
                        if (!pend) begin
                            go   <= 1'b1;
                            req  <= '{op: OP_READ, data: REG_LANE_STAT};
                            pend <= 1'b1;
                        end else if (op_done) begin
                            pend <= 1'b0;
                            pcnt <= pcnt + 1'b1;
                            if (pll_is_locked(rdata)) begin
                                ready_o <= 1'b1;
                                done_o  <= 1'b1;
                                st      <= S_IDLE;
                            end else if (pcnt == LAST_POLL) begin
                                timeout_o <= 1'b1;
                                done_o    <= 1'b1;
                                st        <= S_IDLE;
                            end else begin
                                st <= S_GAP_LOAD;
                            end
                        end
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    p_result_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(ready_o && timeout_o));

    p_done_has_result_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (ready_o || timeout_o));

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_poll_budget_r7: assert property (@(posedge clk) disable iff (rst)
        pcnt <= PC_W'(MAX_POLLS));

    p_flags_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !enable) |=> ready_o);

endmodule

// File: rtl/phy_lock_sequencer.sv
module phy_lock_sequencer
    import phy_lock_pkg::*;
#(
    parameter int POLL_GAP  = 10000,
    parameter int MAX_POLLS = 100,
    parameter int ACK_LIMIT = 1000,
    parameter int WR_HOLD   = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    output logic [15:0] phy_bus,
    output logic        phy_cap_addr,
    output logic        phy_cap_data,
    output logic        phy_wr,
    output logic        phy_rd,
    input  logic        phy_ack,
    input  logic [15:0] phy_dout,
    output logic        seq_done,
    output logic        seq_ready,
    output logic        seq_timeout
);
    logic            go;
    cr_req_t         req;
    logic            op_done;
    logic            op_err;
    logic [CR_W-1:0] rdata;
    logic            gap_load;
    logic            gap_expired;
    cr_strobe_t      strb;

    phy_lock_seq #(
        .MAX_POLLS (MAX_POLLS)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .go          (go),
        .req         (req),
        .op_done     (op_done),
        .op_err      (op_err),
        .rdata       (rdata),
        .gap_load    (gap_load),
        .gap_expired (gap_expired),
        .done_o      (seq_done),
        .ready_o     (seq_ready),
        .timeout_o   (seq_timeout)
    );

    cr_port_master #(
        .ACK_LIMIT (ACK_LIMIT),
        .WR_HOLD   (WR_HOLD)
    ) u_master (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .req     (req),
        .op_done (op_done),
        .op_err  (op_err),
        .rdata   (rdata),
        .strb    (strb),
        .bus     (phy_bus),
        .ack     (phy_ack),
        .dout    (phy_dout)
    );

    gap_timer #(
        .SPAN (POLL_GAP)
    ) u_gap (
        .clk     (clk),
        .rst     (rst),
        .load    (gap_load),
        .expired (gap_expired)
    );

    assign phy_cap_addr = strb.cap_addr;
    assign phy_cap_data = strb.cap_data;
    assign phy_wr       = strb.wr;
    assign phy_rd       = strb.rd;

endmodule

// File: tb/tb_phy_lock_sequencer.sv
module tb_phy_lock_sequencer;
    localparam int GAP  = 8;
    localparam int MAXP = 6;
    localparam int ALIM = 20;
    localparam int WRH  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [15:0] phy_bus;
    logic        phy_cap_addr, phy_cap_data, phy_wr, phy_rd;
    logic        phy_ack = 1'b0;
    logic [15:0] phy_dout = 16'h0;
    logic        seq_done, seq_ready, seq_timeout;

    always #5 clk = ~clk;

    phy_lock_sequencer #(
        .POLL_GAP (GAP), .MAX_POLLS (MAXP), .ACK_LIMIT (ALIM), .WR_HOLD (WRH)
    ) dut (
        .clk (clk), .rst (rst), .enable (enable),
        .phy_bus (phy_bus), .phy_cap_addr (phy_cap_addr), .phy_cap_data (phy_cap_data),
        .phy_wr (phy_wr), .phy_rd (phy_rd), .phy_ack (phy_ack), .phy_dout (phy_dout),
        .seq_done (seq_done), .seq_ready (seq_ready), .seq_timeout (seq_timeout)
    );

    int n_chk = 0;
    int n_bad = 0;

    // PHY model settings and observations
    int          lat = 1, lock_at = 1, fail_mode = 0;
    logic [15:0] noise = 16'h0;
    logic        clr = 1'b0, watch_post = 1'b0;
    int          rst_seen, reads, bad, viol, min_gap, idle_run, post_strobes, done_cnt, acnt;
    logic [15:0] addr_q, dat_q, prev_bus;
    logic        prev_ca, prev_cd, prev_rd, prev_wr;

    wire any_stb = phy_cap_addr | phy_cap_data | phy_rd | phy_wr;
    wire ackable = phy_cap_addr | phy_cap_data | phy_rd;

    always @(posedge clk) begin
        if (rst || clr) begin
            rst_seen <= 0; reads <= 0; bad <= 0; viol <= 0; min_gap <= 1000000;
            idle_run <= 0; post_strobes <= 0; done_cnt <= 0; acnt <= 0;
            addr_q <= 16'h0; dat_q <= 16'h0; phy_ack <= 1'b0;
            prev_ca <= 1'b0; prev_cd <= 1'b0; prev_rd <= 1'b0; prev_wr <= 1'b0; prev_bus <= 16'h0;
        end else begin
            prev_ca <= phy_cap_addr; prev_cd <= phy_cap_data;
            prev_rd <= phy_rd; prev_wr <= phy_wr; prev_bus <= phy_bus;
            if (seq_done) done_cnt <= done_cnt + 1;
            if (phy_cap_addr && !prev_ca) begin
                addr_q <= phy_bus;
                if (phy_bus == 16'h2003 && idle_run < min_gap) min_gap <= idle_run;
            end
            if (phy_cap_data && !prev_cd) dat_q <= phy_bus;
            if (phy_wr && !prev_wr) begin
                if (addr_q == 16'h7F3F && dat_q[0]) rst_seen <= rst_seen + 1;
                else bad <= bad + 1;
                if (reads > 0) bad <= bad + 1;
            end
            if (phy_rd && !prev_rd) begin
                if (addr_q != 16'h2003 || rst_seen == 0) bad <= bad + 1;
                reads <= reads + 1;
                phy_dout <= (reads + 1 >= lock_at) ? (noise | 16'h0002) : (noise & 16'hFFFD);
            end
            if (32'(phy_cap_addr) + 32'(phy_cap_data) + 32'(phy_rd) + 32'(phy_wr) > 1) viol <= viol + 1;
            if (any_stb && (prev_ca | prev_cd | prev_rd | prev_wr) && phy_bus != prev_bus) viol <= viol + 1;
            idle_run <= any_stb ? 0 : idle_run + 1;
            if (watch_post && any_stb) post_strobes <= post_strobes + 1;
            if (ackable && !phy_ack && !(fail_mode == 1 && phy_rd)) begin
                if (acnt >= lat - 1) begin phy_ack <= 1'b1; acnt <= 0; end
                else acnt <= acnt + 1;
            end else if (!ackable && phy_ack && !(fail_mode == 2 && addr_q == 16'h2003)) begin
                if (acnt >= lat - 1) begin phy_ack <= 1'b0; acnt <= 0; end
                else acnt <= acnt + 1;
            end else begin
                acnt <= 0;
            end
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int exp_ready(input int lk, input int fm);
        return (fm == 0 && lk <= MAXP) ? 1 : 0;
    endfunction

    function automatic int exp_reads(input int lk, input int fm);
        if (fm == 1) return 1;
        if (fm == 2) return 0;
        return (lk < MAXP) ? lk : MAXP;
    endfunction

    task automatic run_case(input int lk, input int lt, input logic [15:0] nz,
                            input int fm, input bit poke);
        int waited;
        @(negedge clk);
        lock_at = lk; lat = lt; noise = nz; fail_mode = fm; watch_post = 1'b0; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0; enable = 1'b1;
        @(negedge clk);
        enable = 1'b0;
        chk("R9 flags cleared by enable", int'(seq_ready) + int'(seq_timeout), 0);
        if (poke) begin
            repeat (5) @(negedge clk);
            enable = 1'b1;
            @(negedge clk);
            enable = 1'b0;
        end
        waited = 0;
        while (!seq_done && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        chk("R6 done reached", int'(seq_done), 1);
        chk("R6/R7 ready result", int'(seq_ready), exp_ready(lk, fm));
        chk("R7/R8 timeout result", int'(seq_timeout), 1 - exp_ready(lk, fm));
        chk("R5/R7 read count", reads, exp_reads(lk, fm));
        chk("R2 single reset write", rst_seen, 1);
        chk("R2/R5 op order and addresses", bad, 0);
        chk("R3 strobe/bus protocol", viol, 0);
        if (exp_reads(lk, fm) > 0)
            chk("R4 poll gap honoured", (min_gap >= GAP) ? 1 : 0, 1);
        @(negedge clk);
        chk("R6 done is one cycle", int'(seq_done), 0);
        watch_post = 1'b1;
        repeat (40) @(negedge clk);
        chk("R6/R8 no strobes after end", post_strobes, 0);
        chk("R10 result sticky", int'(seq_ready), exp_ready(lk, fm));
        chk("R10 exclusive flags", int'(seq_ready && seq_timeout), 0);
        chk("R9 one done per run", done_cnt, 1);
        watch_post = 1'b0;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 strobes idle in reset", int'(any_stb), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 strobes idle after reset", int'(any_stb), 0);
        chk("R1 flags low after reset", int'(seq_done) + int'(seq_ready) + int'(seq_timeout), 0);
        // directed corners
        run_case(1, 1, 16'h0000, 0, 1'b0);          // lock on first poll
        run_case(MAXP, 2, 16'hFFFD, 0, 1'b0);       // lock on last allowed poll, R5 noise
        run_case(MAXP + 1, 1, 16'hFFFD, 0, 1'b0);   // never locks in budget, R7
        run_case(3, 1, 16'h5A5A, 1, 1'b0);          // read ack never rises, R8
        run_case(3, 3, 16'h0000, 2, 1'b0);          // ack stuck high, R8
        run_case(4, 2, 16'h1234, 0, 1'b1);          // enable while busy, R9
        // constrained random
        for (int i = 0; i < 12; i++) begin
            run_case(1 + int'($urandom % (MAXP + 2)), 1 + int'($urandom % 5),
                     16'($urandom), 0, 1'b0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule